// File: doc/BRIEF.md
# Configurable Product-Term Macrocell

This block is one output cell of a sum-of-products logic fabric. Eight shared product terms are formed from eight input signals. Each term's AND mask marks every input as used true, used complemented, or ignored. A per-cell selection vector picks which of these shared terms feed the cell's OR gate. Optionally, one further chosen term is XORed into the sum, which lets a single term invert or complement a wide expression cheaply.

The resulting logic value is presented at the output in one of four ways:
- directly, with no storage;
- through a D flip-flop;
- through a toggle flip-flop;
- through a transparent latch.

The flip-flops clock on a selectable edge, or on both edges of the clock. Dual-edge operation uses two single-edge registers and a level-selected multiplexer, so the clock itself is never gated.

All configuration inputs are static. They are changed only while reset is held. The block has no streaming data path: every pin is a plain level signal, so no valid/ready handshake or back-pressure applies.

Top module: `pterm_macrocell`

## Requirements
- R1: Term t uses mask bits [t*N_IN +: N_IN] of both mask vectors. For input i, a set bit in the true mask requires in_bits[i]=1, and a set bit in the complement mask requires in_bits[i]=0. An input with neither bit set is ignored, and an input with both bits set forces the term to 0. A term with no mask bits set is 1.
- R2: The sum is the OR of the terms whose bit is set in sum_sel. Unselected terms have no effect, and an all-zero sum_sel gives a sum of 0.
- R3: When xor_en=1, the logic value is the sum XOR term number xor_term; when xor_en=0 it is the sum alone.
- R4: With store_mode=0 (combinational), mc_out equals the logic value and changes without any clock edge.
- R5: With store_mode=1 (D), mc_out takes the logic value at the active edge and holds otherwise. The active edge is rising for clk_fall=0 and falling for clk_fall=1.
- R6: With store_mode=2 (toggle), mc_out inverts at each active edge where the logic value is 1 and holds where it is 0.
- R7: With store_mode=3 (latch) and clk_fall=0, mc_out follows the logic value while clk is high and holds the value present at the falling edge. With clk_fall=1 it is transparent while clk is low and holds from the rising edge.
- R8: With dual_edge=1, the D and toggle modes update on both clock edges and clk_fall has no effect; latch mode ignores dual_edge.
- R9: rst is asynchronous and active high. It clears the storage to 0 at once, and while rst=1, mc_out is 0 in every storage mode (store_mode 1 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flip-flops and latch enable |
| rst | input | 1 | Asynchronous active-high reset of the storage |
| in_bits | input | N_IN | Logic inputs to the product terms |
| pt_true_mask | input | N_PT*N_IN | Per-term mask of inputs used in true form |
| pt_comp_mask | input | N_PT*N_IN | Per-term mask of inputs used in complemented form |
| sum_sel | input | N_PT | Terms routed to the OR gate |
| xor_en | input | 1 | Enables the XOR with one extra term |
| xor_term | input | clog2(N_PT) | Index of the term fed to the XOR |
| store_mode | input | 2 | 0 combinational, 1 D, 2 toggle, 3 latch |
| clk_fall | input | 1 | Selects falling edge / active-low latch enable |
| dual_edge | input | 1 | Flip-flop modes update on both edges |
| mc_out | output | 1 | Macrocell output |

## Verification
The bench exercises several corner cases, each chosen to expose a specific wrong design:
- A term whose mask marks an input both true and complemented must read 0. A decoder that let one bit win would drive 1.
- A falling-edge D cell must ignore the rising edge, and a rising-edge cell must ignore the falling edge. Swapped edge logic would move the output half a cycle early.
- In dual-edge toggle mode, each edge must invert the output. A design that toggles each register from its own old value instead of from the value currently shown would stall or double-toggle.
- The latch must hold across its closed phase and become transparent again on the next open phase.
- Reset is applied between clock edges, and the output must drop before the next edge. This catches a synchronous reset.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  typedef enum logic [1:0] {
    MODE_COMB  = 2'd0,
    MODE_D     = 2'd1,
    MODE_T     = 2'd2,
    MODE_LATCH = 2'd3
  } store_mode_e;
endpackage

// File: rtl/mc_pterm_array.sv
`timescale 1ns/1ps
module mc_pterm_array #(
  parameter int N_IN = 8,
  parameter int N_PT = 8
) (
  input  logic [N_IN-1:0]      in_bits,
  input  logic [N_PT*N_IN-1:0] true_mask,
  input  logic [N_PT*N_IN-1:0] comp_mask,
  output logic [N_PT-1:0]      terms
);
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_IN-1:0] tm, cm, pass;
    assign tm   = true_mask[t*N_IN +: N_IN];
    assign cm   = comp_mask[t*N_IN +: N_IN];
    // each input passes when it is unused or matches its required level
    assign pass = (~tm | in_bits) & (~cm | ~in_bits);
    assign terms[t] = &pass;
  end
endmodule

// File: rtl/mc_sum_xor.sv
`timescale 1ns/1ps
module mc_sum_xor #(
  parameter int N_PT = 8,
  localparam int PT_W = (N_PT > 1) ? $clog2(N_PT) : 1
) (
  input  logic [N_PT-1:0] terms,
  input  logic [N_PT-1:0] sum_sel,
  input  logic            xor_en,
  input  logic [PT_W-1:0] xor_term,
  output logic            logic_d
);
  logic sum_or, xor_pt;

  assign sum_or  = |(terms & sum_sel);
  assign xor_pt  = xor_en & terms[xor_term];
  assign logic_d = sum_or ^ xor_pt;
endmodule

// File: rtl/mc_storage.sv
`timescale 1ns/1ps
module mc_storage
  import mc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  store_mode_e mode,
  input  logic        clk_fall,
  input  logic        dual_edge,
  input  logic        d,
  output logic        q_out
);
  logic q_r, q_f;
  logic ff_mode;
  logic en_r, en_f;
  logic nxt_r, nxt_f;
  logic held;

  assign ff_mode = (mode == MODE_D) || (mode == MODE_T);

  // rising register: flip-flop on rising/dual edges, or latch hold for active-low enable
  assign en_r = ff_mode ? (dual_edge || !clk_fall) : ((mode == MODE_LATCH) && clk_fall);
  assign en_f = ff_mode ? (dual_edge ||  clk_fall) : ((mode == MODE_LATCH) && !clk_fall);

  // in dual-edge mode the visible state before an edge is the other register
  assign nxt_r = (mode == MODE_T) ? ((dual_edge ? q_f : q_r) ^ d) : d;
  assign nxt_f = (mode == MODE_T) ? ((dual_edge ? q_r : q_f) ^ d) : d;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       q_r <= 1'b0;
    else if (en_r) q_r <= nxt_r;
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst)       f_upd: q_f <= 1'b0;
    else if (en_f) q_f <= nxt_f;
  end

  always_comb begin
    if (dual_edge) held = clk ? q_r : q_f;
    else           held = clk_fall ? q_f : q_r;
    unique case (mode)
      MODE_COMB:  q_out = d;
      MODE_LATCH: q_out = clk_fall ? (clk ? q_r : d) : (clk ? d : q_f);
      default:    q_out = held;
    endcase
    if (rst && (mode != MODE_COMB)) q_out = 1'b0;
  end

  // R5: single rising-edge D register captures the logic value
  a_r5_d_capture: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_D && !dual_edge && !clk_fall) |=> (q_r == $past(d)));

  // R6: single rising-edge toggle register inverts when the logic value is 1
  a_r6_toggle: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_T && !dual_edge && !clk_fall) |=> (q_r == ($past(q_r) ^ $past(d))));

  // R7: active-high latch holds the value present at the falling edge
  a_r7_latch_hold: assert property (@(negedge clk) disable iff (rst)
    (mode == MODE_LATCH && !clk_fall) |=> (q_f == $past(d)));

  // R8: in dual-edge D mode the falling register also captures
  a_r8_dual_fall: assert property (@(negedge clk) disable iff (rst)
    (mode == MODE_D && dual_edge) |=> (q_f == $past(d)));

  // R9: storage is clear whenever reset is seen high
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |-> (q_r == 1'b0 && q_f == 1'b0));
endmodule

// File: rtl/pterm_macrocell.sv
`timescale 1ns/1ps
module pterm_macrocell
  import mc_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int N_PT = 8,
  localparam int PT_W = (N_PT > 1) ? $clog2(N_PT) : 1,
  localparam int MASK_W = N_PT * N_IN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   in_bits,
  input  logic [MASK_W-1:0] pt_true_mask,
  input  logic [MASK_W-1:0] pt_comp_mask,
  input  logic [N_PT-1:0]   sum_sel,
  input  logic              xor_en,
  input  logic [PT_W-1:0]   xor_term,
  input  logic [1:0]        store_mode,
  input  logic              clk_fall,
  input  logic              dual_edge,
  output logic              mc_out
);
  logic [N_PT-1:0] terms;
  logic            logic_d;
  store_mode_e     mode;

  assign mode = store_mode_e'(store_mode);

  mc_pterm_array #(.N_IN(N_IN), .N_PT(N_PT)) u_terms (
    .in_bits   (in_bits),
    .true_mask (pt_true_mask),
    .comp_mask (pt_comp_mask),
    .terms     (terms)
  );

  mc_sum_xor #(.N_PT(N_PT)) u_sum (
    .terms    (terms),
    .sum_sel  (sum_sel),
    .xor_en   (xor_en),
    .xor_term (xor_term),
    .logic_d  (logic_d)
  );

  mc_storage u_store (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .clk_fall  (clk_fall),
    .dual_edge (dual_edge),
    .d         (logic_d),
    .q_out     (mc_out)
  );
endmodule

// File: tb/tb_pterm_macrocell.sv
`timescale 1ns/1ps
module tb_pterm_macrocell;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_bits = '0;
  logic [63:0] pt_true_mask = '0;
  logic [63:0] pt_comp_mask = '0;
  logic [7:0]  sum_sel = '0;
  logic        xor_en = 1'b0;
  logic [2:0]  xor_term = '0;
  logic [1:0]  store_mode = 2'd0;
  logic        clk_fall = 1'b0;
  logic        dual_edge = 1'b0;
  logic        mc_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pterm_macrocell dut (
    .clk(clk), .rst(rst), .in_bits(in_bits),
    .pt_true_mask(pt_true_mask), .pt_comp_mask(pt_comp_mask),
    .sum_sel(sum_sel), .xor_en(xor_en), .xor_term(xor_term),
    .store_mode(store_mode), .clk_fall(clk_fall), .dual_edge(dual_edge),
    .mc_out(mc_out)
  );

  task automatic chk(input string req, input logic exp);
    n_vec++;
    if (mc_out !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, mc_out, exp);
    end
  endtask

  task automatic clear_cfg();
    pt_true_mask = '0; pt_comp_mask = '0; sum_sel = '0;
    xor_en = 1'b0; xor_term = '0;
  endtask

  // logic value becomes in_bits[0] via term 0
  task automatic cfg_follow_in0();
    clear_cfg();
    pt_true_mask[0] = 1'b1;
    sum_sel = 8'b1;
  endtask

  task automatic begin_mode(input logic [1:0] m, input logic f, input logic de, input logic in0);
    rst = 1'b1;
    store_mode = m; clk_fall = f; dual_edge = de;
    cfg_follow_in0();
    in_bits = {7'd0, in0};
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic t_reset();
    #0.3 store_mode = 2'd1; cfg_follow_in0(); in_bits = 8'h01;
    #0.3 chk("R9 reset state", 1'b0);
    @(posedge clk); #0.5 chk("R9 held in reset", 1'b0);
  endtask

  task automatic t_terms();
    rst = 1'b0; store_mode = 2'd0; clear_cfg();
    // term 3 (bits [31:24]): in0 and in3 true, in5 complemented
    pt_true_mask[24] = 1'b1; pt_true_mask[27] = 1'b1; pt_comp_mask[29] = 1'b1;
    sum_sel = 8'b0000_1000;
    in_bits = 8'h09; #0.4 chk("R1 true/comp match", 1'b1);
    in_bits = 8'h29; #0.4 chk("R1 comp input high", 1'b0);
    in_bits = 8'h08; #0.4 chk("R1 true input low", 1'b0);
    in_bits = 8'hC9; #0.4 chk("R1 dont-care inputs", 1'b1);
    clear_cfg(); sum_sel = 8'b0000_1000;
    in_bits = 8'h00; #0.4 chk("R1 empty term is 1", 1'b1);
    pt_true_mask[26] = 1'b1; pt_comp_mask[26] = 1'b1;
    in_bits = 8'h04; #0.4 chk("R1 both bits forces 0 (in=1)", 1'b0);
    in_bits = 8'h00; #0.4 chk("R1 both bits forces 0 (in=0)", 1'b0);
  endtask

  task automatic t_sum();
    clear_cfg();
    pt_true_mask[2*8+1] = 1'b1;                              // term 2: in1
    pt_true_mask[5*8+7] = 1'b1; pt_comp_mask[5*8+6] = 1'b1;  // term 5: in7 & ~in6
    sum_sel = 8'b0010_0100;                                  // term 4 left empty (=1) but unselected
    in_bits = 8'h00; #0.4 chk("R2 none true", 1'b0);
    in_bits = 8'h02; #0.4 chk("R2 term2", 1'b1);
    in_bits = 8'h80; #0.4 chk("R2 term5", 1'b1);
    in_bits = 8'hC0; #0.4 chk("R2 unselected ignored", 1'b0);
    in_bits = 8'hC2; #0.4 chk("R2 term2 alone", 1'b1);
    sum_sel = 8'h00; in_bits = 8'h82; #0.4 chk("R2 empty select", 1'b0);
  endtask

  task automatic t_xor();
    clear_cfg();
    pt_true_mask[1*8+0] = 1'b1; sum_sel = 8'b0000_0010;      // term 1: in0
    pt_true_mask[6*8+4] = 1'b1; xor_en = 1'b1; xor_term = 3'd6; // term 6: in4
    in_bits = 8'h00; #0.4 chk("R3 0^0", 1'b0);
    in_bits = 8'h01; #0.4 chk("R3 1^0", 1'b1);
    in_bits = 8'h10; #0.4 chk("R3 0^1", 1'b1);
    in_bits = 8'h11; #0.4 chk("R3 1^1", 1'b0);
    xor_en = 1'b0; in_bits = 8'h10; #0.4 chk("R3 xor disabled", 1'b0);
  endtask

  task automatic t_comb();
    store_mode = 2'd0; cfg_follow_in0();
    @(posedge clk); #0.5 in_bits = 8'h01; #0.5 chk("R4 follows mid-phase", 1'b1);
    in_bits = 8'h00; #0.5 chk("R4 follows again", 1'b0);
  endtask

  task automatic t_dff();
    begin_mode(2'd1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); #0.5 in_bits = 8'h01; #0.5 chk("R5 rise holds before edge", 1'b0);
    @(posedge clk); #0.5 chk("R5 rise capture", 1'b1);
    in_bits = 8'h00;
    @(negedge clk); #0.5 chk("R5 rise ignores fall", 1'b1);
    @(posedge clk); #0.5 chk("R5 rise capture 0", 1'b0);
    begin_mode(2'd1, 1'b1, 1'b0, 1'b0);
    @(posedge clk); #0.5 in_bits = 8'h01; #0.5 chk("R5 fall ignores rise", 1'b0);
    @(negedge clk); #0.5 chk("R5 fall capture", 1'b1);
    in_bits = 8'h00;
    @(posedge clk); #0.5 chk("R5 fall holds at rise", 1'b1);
    @(negedge clk); #0.5 chk("R5 fall capture 0", 1'b0);
  endtask

  task automatic t_tff();
    begin_mode(2'd2, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #0.5 chk("R6 toggle 1", 1'b1);
    @(negedge clk); #0.5 chk("R6 no toggle on fall", 1'b1);
    @(posedge clk); #0.5 chk("R6 toggle 2", 1'b0);
    @(posedge clk); #0.5 chk("R6 toggle 3", 1'b1);
    in_bits = 8'h00;
    @(posedge clk); #0.5 chk("R6 hold with 0", 1'b1);
    @(posedge clk); #0.5 chk("R6 hold with 0 again", 1'b1);
    begin_mode(2'd2, 1'b1, 1'b0, 1'b1);
    @(negedge clk); #0.5 chk("R6 fall toggle 1", 1'b1);
    @(posedge clk); #0.5 chk("R6 fall ignores rise", 1'b1);
    @(negedge clk); #0.5 chk("R6 fall toggle 2", 1'b0);
  endtask

  task automatic t_latch();
    begin_mode(2'd3, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #0.5 in_bits = 8'h01; #0.3 chk("R7 high transparent 1", 1'b1);
    in_bits = 8'h00; #0.3 chk("R7 high transparent 0", 1'b0);
    in_bits = 8'h01; #0.3 chk("R7 high transparent 1b", 1'b1);
    @(negedge clk); #0.5 chk("R7 holds at fall", 1'b1);
    in_bits = 8'h00; #0.3 chk("R7 closed ignores input", 1'b1);
    @(posedge clk); #0.5 chk("R7 reopens", 1'b0);
    begin_mode(2'd3, 1'b1, 1'b0, 1'b0);
    @(negedge clk); #0.5 in_bits = 8'h01; #0.3 chk("R7 low transparent", 1'b1);
    @(posedge clk); #0.5 in_bits = 8'h00; #0.3 chk("R7 low-enable holds at rise", 1'b1);
    @(negedge clk); #0.5 chk("R7 low reopens", 1'b0);
  endtask

  task automatic t_dual();
    begin_mode(2'd1, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #0.5 in_bits = 8'h01;
    @(negedge clk); #0.5 chk("R8 dual D on fall", 1'b1);
    in_bits = 8'h00;
    @(posedge clk); #0.5 chk("R8 dual D on rise", 1'b0);
    begin_mode(2'd2, 1'b1, 1'b1, 1'b1);
    @(negedge clk); #0.5 chk("R8 dual T edge 1", 1'b1);
    @(posedge clk); #0.5 chk("R8 dual T edge 2", 1'b0);
    @(negedge clk); #0.5 chk("R8 dual T edge 3", 1'b1);
    @(posedge clk); #0.5 chk("R8 dual T edge 4", 1'b0);
    begin_mode(2'd3, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #0.5 in_bits = 8'h01; #0.3 chk("R8 latch ignores dual open", 1'b1);
    @(negedge clk); #0.5 in_bits = 8'h00; #0.3 chk("R8 latch ignores dual closed", 1'b1);
  endtask

  task automatic t_async();
    begin_mode(2'd1, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #0.5 chk("R9 pre-reset value", 1'b1);
    #0.5 rst = 1'b1; #0.3 chk("R9 async clear", 1'b0);
    @(posedge clk); #0.5 chk("R9 stays clear", 1'b0);
    @(posedge clk); #1 rst = 1'b0;
    @(posedge clk); #0.5 chk("R9 resumes after release", 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_terms();
    t_sum();
    t_xor();
    t_comb();
    t_dff();
    t_tff();
    t_latch();
    t_dual();
    t_async();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule